// File: doc/BRIEF.md
# Wake Event Status Aggregator

This block collects wake-up events from a fixed set of board-level inputs and turns them into one active-low, open-drain power-management request. The inputs are two ring-indicator lines, a ring line, the keyboard data line, the mouse data line and a group of general-purpose inputs. Every input is brought into the clock domain by a two-flop synchroniser and then watched for its active edge. Each detected edge latches a per-source status bit. The status bit stays set until software clears it by writing a one to it.

Each status bit has an enable bit at the same position. Only enabled, pending sources may pull the output. A master enable decides whether anything can reach the pin. A global status flag records that some source had an event, whatever the master enable is set to. A cascaded management-event request can also drive the output, but only when two separate enable bits are both set. Software reaches everything through a small 8-bit register bus with a write strobe and a combinational read path.

Top module: `wake_event_hub`

## Requirements
- R1: After reset, every register reads 0 and the wake output is released (wake_oe = 0). The registers are status at addresses 0 and 1, enable at 2 and 3, control at 4 and polarity at 5.
- R2: A falling edge on a fixed source sets its status bit. The bit positions are ri_a_n at 0, ri_b_n at 1, ring_n at 2, kbd_dat at 3 and mou_dat at 4. General-purpose input i uses bit 5+i. Bits 0–7 are read at address 0 and bits 8 and above at address 1, bit 8 in data bit 0. A rising edge on a fixed source sets nothing.
- R3: Bit i of the polarity register (address 5) selects the active edge of general-purpose input i: 1 means rising, 0 means falling. The opposite edge sets nothing.
- R4: A status bit sets even while its enable bit is clear. Writing a 1 to a status bit position clears that bit. Writing a 0 leaves it unchanged.
- R5: If a write-one-to-clear lands in the same cycle as a new event on the same bit, the status bit stays set.
- R6: wake_oe is the registered value of master-enable AND (OR over all sources of status AND enable, OR the management term). The master enable is control bit 0. With the master enable clear, wake_oe never asserts.
- R7: An event recorded while its enable bit is clear asserts wake_oe as soon as that enable bit is set, provided the master enable is set.
- R8: Global status (control bit 1) sets on any source event, whatever the master enable holds. Writing 1 to control bit 1 clears it.
- R9: The synchronised level on mgmt_req drives wake_oe only when both control bit 2 (device-interrupt enable) and control bit 3 (management-to-wake enable) are set.
- R10: wake_o is held at 0 at all times, so the pin only sinks current or floats.
- R11: The enable registers read back as written, at the same bit positions as the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low standby-power reset |
| ri_a_n | input | 1 | Ring indicator A, falling edge active |
| ri_b_n | input | 1 | Ring indicator B, falling edge active |
| ring_n | input | 1 | Ring line, falling edge active |
| kbd_dat | input | 1 | Keyboard data line, falling edge active |
| mou_dat | input | 1 | Mouse data line, falling edge active |
| gp_in | input | NGP | General-purpose wake inputs |
| mgmt_req | input | 1 | Management-event group request, level |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| wake_oe | output | 1 | Output enable of the open-drain wake pin; 1 pulls low |
| wake_o | output | 1 | Data value of the wake pin, always 0 |

## Verification
The bench uses the default NGP = 8, which gives 13 sources. The status and enable vectors then cross the byte boundary between addresses 0 and 1, so the split of the bit lanes gets exercised. The bench walks every source for its active edge and its inactive edge, and tries both polarity settings on every general-purpose input. It then crosses every pending source with every single-bit enable pattern and computes the expected output. All four combinations of the two management enables are also covered. The same-cycle clear-versus-event race is staged at a known cycle.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam int NFIX = 5;

    localparam logic [2:0] A_STS_LO = 3'd0;
    localparam logic [2:0] A_STS_HI = 3'd1;
    localparam logic [2:0] A_EN_LO  = 3'd2;
    localparam logic [2:0] A_EN_HI  = 3'd3;
    localparam logic [2:0] A_CTRL   = 3'd4;
    localparam logic [2:0] A_POL    = 3'd5;

    localparam int C_GEN  = 0;
    localparam int C_GSTS = 1;
    localparam int C_DIE  = 2;
    localparam int C_MWE  = 3;
endpackage

// File: rtl/wake_sync_edge.sv
module wake_sync_edge #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] rise_sel,
    output logic [W-1:0] evt
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
        logic [1:0]   warm;
    } st_t;

    st_t q, d;
    logic armed;

    assign armed = (q.warm == 2'd3);

    always_comb begin
        d      = q;
        d.s1   = pins;
        d.s2   = q.s1;
        d.s3   = q.s2;
        d.warm = armed ? q.warm : q.warm + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.s1   <= '1;
            q.s2   <= '1;
            q.s3   <= '1;
            q.warm <= 2'd0;
        end else begin
            q <= d;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign evt[i] = armed & (rise_sel[i] ? (q.s2[i] & ~q.s3[i])
                                             : (q.s3[i] & ~q.s2[i]));
    end

    // R2: no event fires while the synchroniser pipeline is still filling
    p_quiet_warmup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.warm != 2'd3) |-> (evt == '0));
endmodule

// File: rtl/wake_regs.sv
module wake_regs
    import wake_pkg::*;
#(
    parameter int NSRC = 13,
    parameter int NGP  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic            wr_en,
    input  logic [2:0]      addr,
    input  logic [7:0]      wdata,
    output logic [7:0]      rdata,
    output logic [NSRC-1:0] sts,
    output logic [NSRC-1:0] en,
    output logic            gen,
    output logic            die,
    output logic            mwe,
    output logic [NGP-1:0]  pol
);
    typedef struct packed {
        logic [NSRC-1:0] sts;
        logic [NSRC-1:0] en;
        logic            gen;
        logic            gsts;
        logic            die;
        logic            mwe;
        logic [NGP-1:0]  pol;
    } rg_t;

    rg_t q, d;
    logic [NSRC-1:0] clr;
    logic            gclr;

    always_comb begin
        d    = q;
        clr  = '0;
        gclr = 1'b0;
        for (int b = 0; b < NSRC; b++) begin
            if (wr_en && addr == ((b < 8) ? A_STS_LO : A_STS_HI))
                clr[b] = wdata[b % 8];
            if (wr_en && addr == ((b < 8) ? A_EN_LO : A_EN_HI))
                d.en[b] = wdata[b % 8];
        end
        if (wr_en && addr == A_CTRL) begin
            d.gen = wdata[C_GEN];
            d.die = wdata[C_DIE];
            d.mwe = wdata[C_MWE];
            gclr  = wdata[C_GSTS];
        end
        if (wr_en && addr == A_POL)
            d.pol = wdata[NGP-1:0];
        d.sts  = (q.sts & ~clr) | evt;
        d.gsts = (q.gsts & ~gclr) | (|evt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_STS_LO, A_STS_HI, A_EN_LO, A_EN_HI: begin
                for (int b = 0; b < NSRC; b++) begin
                    if (addr == ((b < 8) ? A_STS_LO : A_STS_HI))
                        rdata[b % 8] = q.sts[b];
                    if (addr == ((b < 8) ? A_EN_LO : A_EN_HI))
                        rdata[b % 8] = q.en[b];
                end
            end
            A_CTRL: rdata = {4'b0, q.mwe, q.die, q.gsts, q.gen};
            A_POL:  rdata[NGP-1:0] = q.pol;
            default: rdata = '0;
        endcase
    end

    assign sts = q.sts;
    assign en  = q.en;
    assign gen = q.gen;
    assign die = q.die;
    assign mwe = q.mwe;
    assign pol = q.pol;

    // R5: a detected event always leaves its status bit set, even under a clear
    p_evt_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((q.sts & $past(evt)) == $past(evt)));
    // R2: status bits rise only from a detected event
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q.sts & ~$past(q.sts) & ~$past(evt)) == '0));
    // R4: a one written to status bit 0 clears it when no event competes
    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STS_LO && wdata[0] && !evt[0]) |=> !q.sts[0]);
    // R8: global status follows any event
    p_gsts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> q.gsts);
endmodule

// File: rtl/wake_event_hub.sv
module wake_event_hub
    import wake_pkg::*;
#(
    parameter int NGP = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ri_a_n,
    input  logic           ri_b_n,
    input  logic           ring_n,
    input  logic           kbd_dat,
    input  logic           mou_dat,
    input  logic [NGP-1:0] gp_in,
    input  logic           mgmt_req,
    input  logic           wr_en,
    input  logic [2:0]     addr,
    input  logic [7:0]     wdata,
    output logic [7:0]     rdata,
    output logic           wake_oe,
    output logic           wake_o
);
    // NGP is limited to 1..8: one polarity byte, status fits two bytes
    localparam int NSRC = NFIX + NGP;

    logic [NSRC-1:0] pins, rise_sel, evt, sts, en;
    logic [NGP-1:0]  pol;
    logic            gen, die, mwe;

    assign pins     = {gp_in, mou_dat, kbd_dat, ring_n, ri_b_n, ri_a_n};
    assign rise_sel = {pol, {NFIX{1'b0}}};

    wake_sync_edge #(.W(NSRC)) u_edge (
        .clk(clk), .rst_n(rst_n), .pins(pins), .rise_sel(rise_sel), .evt(evt)
    );

    wake_regs #(.NSRC(NSRC), .NGP(NGP)) u_regs (
        .clk(clk), .rst_n(rst_n), .evt(evt),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .sts(sts), .en(en), .gen(gen), .die(die), .mwe(mwe), .pol(pol)
    );

    typedef struct packed {
        logic m1;
        logic m2;
        logic wake;
    } out_t;

    out_t q, d;

    always_comb begin
        d      = q;
        d.m1   = mgmt_req;
        d.m2   = q.m1;
        d.wake = gen & ((|(sts & en)) | (q.m2 & die & mwe));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wake_oe = q.wake;
    assign wake_o  = 1'b0;

    // R6: master enable off means the pin is released next cycle
    p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !gen |=> !wake_oe);
    // R7: any enabled pending source with master enable asserts the pin
    p_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gen && (|(sts & en))) |=> wake_oe);
    // R9: management path is blocked unless both of its enables are set
    p_mgmt_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(die && mwe) && ((sts & en) == '0)) |=> !wake_oe);
endmodule

// File: tb/wake_event_hub_test.sv
module wake_event_hub_test;
    localparam int NGP  = 8;
    localparam int NSRC = 5 + NGP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSRC-1:0] src = '1;
    logic mgmt_req = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic wake_oe, wake_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wake_event_hub #(.NGP(NGP)) uut (
        .clk(clk), .rst_n(rst_n),
        .ri_a_n(src[0]), .ri_b_n(src[1]), .ring_n(src[2]),
        .kbd_dat(src[3]), .mou_dat(src[4]), .gp_in(src[NSRC-1:5]),
        .mgmt_req(mgmt_req), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wake_oe(wake_oe), .wake_o(wake_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic rd_sts(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(3'd0, lo);
        rd(3'd1, hi);
        v = {hi, lo};
    endtask

    task automatic clear_all();
        wr(3'd0, 8'hFF);
        wr(3'd1, 8'hFF);
        wr(3'd4, 8'h02);
    endtask

    task automatic set_en(input logic [15:0] m);
        wr(3'd2, m[7:0]);
        wr(3'd3, m[15:8]);
    endtask

    // falling-edge pulse on source i (all polarities falling)
    task automatic pulse(input int i);
        @(negedge clk); src[i] = 1'b0;
        tick(4);
        src[i] = 1'b1;
        tick(4);
    endtask

    initial begin
        logic [15:0] s;
        logic [7:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(5);

        // R1 reset values
        for (int a = 0; a < 6; a++) begin
            rd(a[2:0], v);
            check("R1 reset register", v, 0);
        end
        check("R1 reset wake_oe", wake_oe, 0);
        check("R10 wake_o low", wake_o, 0);

        // R2 / R4 / R8 fixed sources, master enable off
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); src[i] = 1'b0;
            tick(4);
            rd_sts(s);
            check("R2 falling edge sets bit", s, 1 << i);
            check("R4 set with enable clear", s[i], 1);
            rd(3'd4, v);
            check("R8 gsts with gen off", v, 8'h02);
            check("R6 no wake with gen off", wake_oe, 0);
            src[i] = 1'b1;
            tick(4);
            rd_sts(s);
            check("R2 rising edge ignored", s, 1 << i);
            wr(3'd0, 8'h00);
            rd_sts(s);
            check("R4 write zero no effect", s, 1 << i);
            wr(3'd0, 8'(1 << i));
            rd_sts(s);
            check("R4 write one clears", s, 0);
            wr(3'd4, 8'h02);
            rd(3'd4, v);
            check("R8 gsts clears", v, 0);
        end

        // R3 general-purpose polarity sweep
        for (int i = 0; i < NGP; i++) begin
            for (int p = 0; p < 2; p++) begin
                wr(3'd5, p ? 8'(1 << i) : 8'h00);
                rd(3'd5, v);
                check("R3 polarity readback", v, p ? (1 << i) : 0);
                @(negedge clk); src[5+i] = 1'b0;
                tick(4);
                rd_sts(s);
                check("R3 first edge", s, p ? 0 : (1 << (5 + i)));
                src[5+i] = 1'b1;
                tick(4);
                rd_sts(s);
                check("R3 second edge", s, 1 << (5 + i));
                clear_all();
            end
        end
        wr(3'd5, 8'h00);

        // R11 enable readback across both bytes
        set_en(16'h1A5C);
        wr(3'd2, 8'h5C);
        rd(3'd2, v); check("R11 enable low byte", v, 8'h5C);
        rd(3'd3, v); check("R11 enable high byte", v, 8'h1A);
        set_en(16'h0000);

        // R6 / R7 source x enable cross, master enable on
        wr(3'd4, 8'h01);
        for (int i = 0; i < NSRC; i++) begin
            pulse(i);
            tick(1);
            check("R7 held while disabled", wake_oe, 0);
            for (int j = 0; j < NSRC; j++) begin
                set_en(16'(1 << j));
                tick(2);
                check("R6 wake vs enable", wake_oe, (i == j) ? 1 : 0);
            end
            set_en(16'(1 << i));
            tick(2);
            check("R7 wake after enable", wake_oe, 1);
            wr(3'd4, 8'h00);
            tick(2);
            check("R6 gen off releases", wake_oe, 0);
            set_en(16'h0000);
            clear_all();
            wr(3'd4, 8'h01);
        end
        wr(3'd4, 8'h00);

        // R9 management path
        mgmt_req = 1'b1;
        for (int c = 0; c < 4; c++) begin
            wr(3'd4, 8'(1 | (c << 2)));
            tick(4);
            check("R9 mgmt gating", wake_oe, (c == 3) ? 1 : 0);
        end
        wr(3'd4, 8'h0C);
        tick(4);
        check("R9 mgmt needs gen (R6)", wake_oe, 0);
        mgmt_req = 1'b0;
        wr(3'd4, 8'h00);

        // R5 clear racing a new event on ring (bit 2)
        pulse(2);
        @(negedge clk); src[2] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd0; wdata = 8'h04;
        @(negedge clk);
        wr_en = 1'b0;
        rd_sts(s);
        check("R5 event beats clear", s, 16'h0004);
        wr(3'd0, 8'h04);
        rd_sts(s);
        check("R5 later clear works", s, 0);
        src[2] = 1'b1;
        tick(4);
        check("R10 wake_o still low", wake_o, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule